// File: doc/BRIEF.md
# JTAG Debug Test Access Port

This block is the scan front end of a debug transport. A standard sixteen-state test access port controller runs on the test clock. Its state moves on the test mode select input. A test reset input, active low, puts the controller back to its reset state asynchronously. Nothing on the system side can reset it.

An instruction register, at least five bits wide, chooses the data register that sits between the serial input and the serial output. The choices are:
- a read-only identification register;
- a one-bit bypass cell;
- one of two external debug scan registers: a control/status register and a debug-bus access register.

For the external registers the block gives a select line for each register, plus capture, shift and update strobes. An outside register samples these strobes on the rising test clock edge. It shifts from the serial input and returns its low bit on a dedicated input.

The serial interface is a plain synchronous scan path, not a stream. There is no valid/ready handshake and no back-pressure. One bit moves on every test clock edge while the controller is in a shift state. The serial output changes on the falling edge and is enabled only while shifting. A separate output shows when the controller is in Run-Test/Idle.

Top module: `tap_debug_port`

## Requirements
- R1: Driving `trst_n` low immediately, without a clock edge, returns the controller to Test-Logic-Reset. It clears `tdo_oe` and both external selects, and loads the instruction register with the identification code 0x01 (zero-extended to the register width).
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. One further edge in that state loads the identification instruction into the instruction register.
- R3: In Capture-IR the instruction shift register loads the pattern ...00001. It shifts out least significant bit first, so the first bit seen on `tdo` is 1 and the rest are 0.
- R4: Code 0x00, and the all-ones code of the register width, select the one-bit bypass cell. It captures 0 in Capture-DR. The bits shifted out are therefore a 0 followed by the input bits, each delayed by one position.
- R5: Code 0x01 selects a 32-bit read-only identification register, shifted out LSB first. Its layout is version in bits 31:28, part number in 27:12, manufacturer in 11:1, and 1 in bit 0. Bits shifted in never change the value captured next.
- R6: Code 0x10 raises `ext_sel_ctrl` and routes `ext_tdo_ctrl` to `tdo`. Code 0x11 raises `ext_sel_bus` and routes `ext_tdo_bus`. At most one select is high at any time.
- R7: Every other code selects the bypass cell. This includes 0x12 to 0x17, and any code that has bits set above bit 4 other than the all-ones code.
- R8: While an external register is selected, `ext_capture` is high for the single cycle spent in Capture-DR, `ext_shift` is high for each cycle in Shift-DR, and `ext_update` is high for the single cycle in Update-DR. None of the three strobes rises when no external register is selected.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only in the half-cycles that follow entry into Shift-IR or Shift-DR.
- R10: `run_idle` is high exactly while the controller is in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial scan input; external registers shift it directly |
| ext_tdo_ctrl | input | 1 | Low bit of the external control/status scan register |
| ext_tdo_bus | input | 1 | Low bit of the external debug-bus access scan register |
| tdo | output | 1 | Serial scan output, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`, high while shifting |
| ext_sel_ctrl | output | 1 | Control/status scan register selected |
| ext_sel_bus | output | 1 | Debug-bus access scan register selected |
| ext_capture | output | 1 | Capture strobe for the selected external register |
| ext_shift | output | 1 | Shift strobe for the selected external register |
| ext_update | output | 1 | Update strobe for the selected external register |
| run_idle | output | 1 | Controller is in Run-Test/Idle |

## Verification
The bench builds the port with a six-bit instruction register. It uses a nonzero version, part number and manufacturer, so every IDCODE field is visible in the shifted word.

The wider register brings the extension rule within reach. Codes such as 0x30 and 0x31 share their low five bits with the two debug codes and must fall to bypass. Code 0x1f is no longer the bypass code, yet still lands on bypass as an unimplemented code, while the all-ones code 0x3f is the true bypass encoding.

Random walks through the controller, followed by five high `tms` cycles, test the reset path from states reached by chance with arbitrary instruction values.

// File: rtl/tap_debug_pkg.sv
package tap_debug_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS, PATH_IDCODE, PATH_CTRL, PATH_BUS
  } scan_path_e;

  localparam logic [4:0] CODE_IDCODE = 5'h01;
  localparam logic [4:0] CODE_CTRL   = 5'h10;
  localparam logic [4:0] CODE_BUS    = 5'h11;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_debug_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_debug_pkg::*;
#(
  parameter int IR_W = 5
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output scan_path_e path
);

  localparam logic [IR_W-1:0] IR_RESET   = IR_W'(CODE_IDCODE);
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
  localparam logic [IR_W-1:0] IR_CTRL    = IR_W'(CODE_CTRL);
  localparam logic [IR_W-1:0] IR_BUS     = IR_W'(CODE_BUS);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  generate
    if (IR_W < 5) begin : g_bad_width
      initial $display("tap_ir: instruction register narrower than five bits");
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= IR_RESET;
    else if (state == ST_RESET)  ir_q <= IR_RESET;
    else if (state == ST_UPD_IR) ir_q <= ir_sr;
  end

  always_comb begin
    if      (ir_q == IR_RESET) path = PATH_IDCODE;
    else if (ir_q == IR_CTRL)  path = PATH_CTRL;
    else if (ir_q == IR_BUS)   path = PATH_BUS;
    else                       path = PATH_BYPASS;
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_debug_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h0001,
  parameter logic [10:0] ID_MANUF   = 11'h001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  scan_path_e path,
  input  logic       tdi,
  input  logic       ext_tdo_ctrl,
  input  logic       ext_tdo_bus,
  output logic       dr_lsb
);

  localparam int          ID_W   = 32;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MANUF, 1'b1};

  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= ID_VALUE;
      byp_q <= 1'b0;
    end else if (state == ST_CAP_DR) begin
      id_sr <= ID_VALUE;
      byp_q <= 1'b0;
    end else if (state == ST_SH_DR) begin
      if (path == PATH_IDCODE) id_sr <= {tdi, id_sr[ID_W-1:1]};
      if (path == PATH_BYPASS) byp_q <= tdi;
    end
  end

  always_comb begin
    case (path)
      PATH_IDCODE: dr_lsb = id_sr[0];
      PATH_CTRL:   dr_lsb = ext_tdo_ctrl;
      PATH_BUS:    dr_lsb = ext_tdo_bus;
      default:     dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/tap_debug_port.sv
module tap_debug_port
  import tap_debug_pkg::*;
#(
  parameter int          IR_W       = 5,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h0001,
  parameter logic [10:0] ID_MANUF   = 11'h001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic ext_tdo_ctrl,
  input  logic ext_tdo_bus,
  output logic tdo,
  output logic tdo_oe,
  output logic ext_sel_ctrl,
  output logic ext_sel_bus,
  output logic ext_capture,
  output logic ext_shift,
  output logic ext_update,
  output logic run_idle
);

  tap_state_e state;
  scan_path_e path;
  logic       ir_lsb;
  logic       dr_lsb;
  logic       ext_any;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  tap_ir #(.IR_W(IR_W)) u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_lsb (ir_lsb),
    .path   (path)
  );

  tap_dr #(
    .ID_VERSION (ID_VERSION),
    .ID_PART    (ID_PART),
    .ID_MANUF   (ID_MANUF)
  ) u_dr (
    .tck          (tck),
    .trst_n       (trst_n),
    .state        (state),
    .path         (path),
    .tdi          (tdi),
    .ext_tdo_ctrl (ext_tdo_ctrl),
    .ext_tdo_bus  (ext_tdo_bus),
    .dr_lsb       (dr_lsb)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  assign ext_sel_ctrl = (path == PATH_CTRL);
  assign ext_sel_bus  = (path == PATH_BUS);
  assign ext_any      = ext_sel_ctrl || ext_sel_bus;
  assign ext_capture  = ext_any && (state == ST_CAP_DR);
  assign ext_shift    = ext_any && (state == ST_SH_DR);
  assign ext_update   = ext_any && (state == ST_UPD_DR);
  assign run_idle     = (state == ST_IDLE);

endmodule

// File: rtl/tap_debug_port_chk.sv
module tap_debug_port_chk (
  input logic tck,
  input logic trst_n,
  input logic tms,
  input logic tdi,
  input logic ext_tdo_ctrl,
  input logic ext_tdo_bus,
  input logic tdo,
  input logic tdo_oe,
  input logic ext_sel_ctrl,
  input logic ext_sel_bus,
  input logic ext_capture,
  input logic ext_shift,
  input logic ext_update,
  input logic run_idle
);

  AST_ONE_SELECT: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({ext_sel_ctrl, ext_sel_bus})); // R6

  AST_ONE_STROBE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({ext_capture, ext_shift, ext_update})); // R8

  AST_STROBE_NEEDS_SEL: assert property (@(posedge tck) disable iff (!trst_n)
    (ext_capture || ext_shift || ext_update) |-> (ext_sel_ctrl || ext_sel_bus)); // R8

  AST_CAPTURE_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
    ext_capture |=> !ext_capture); // R8

  AST_UPDATE_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
    ext_update |=> (!ext_update && !ext_shift)); // R8

  AST_SEL_STABLE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    ext_shift |=> ($stable(ext_sel_ctrl) && $stable(ext_sel_bus))); // R6

  AST_IDLE_NOT_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    !(run_idle && (ext_shift || ext_capture || ext_update))); // R10

endmodule

bind tap_debug_port tap_debug_port_chk chk_i (.*);

// File: tb/tap_debug_port_tb_top.sv
`timescale 1ns/1ps
module tap_debug_port_tb_top;

  localparam int          IR_W  = 6;
  localparam logic [3:0]  VER   = 4'h3;
  localparam logic [15:0] PART  = 16'hBEEF;
  localparam logic [10:0] MANUF = 11'h2A5;
  localparam logic [7:0]  CTRL_CAP = 8'hA5;
  localparam logic [11:0] BUS_CAP  = 12'h3C6;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0;
  logic ext_tdo_ctrl, ext_tdo_bus;
  logic tdo, tdo_oe, ext_sel_ctrl, ext_sel_bus, ext_capture, ext_shift, ext_update, run_idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cap_cnt = 0, upd_cnt = 0;

  logic [7:0]  ctrl_reg = '0;
  logic [11:0] bus_reg  = '0;

  always #5 tck = ~tck;

  tap_debug_port #(.IR_W(IR_W), .ID_VERSION(VER), .ID_PART(PART), .ID_MANUF(MANUF)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .ext_tdo_ctrl(ext_tdo_ctrl), .ext_tdo_bus(ext_tdo_bus),
    .tdo(tdo), .tdo_oe(tdo_oe), .ext_sel_ctrl(ext_sel_ctrl), .ext_sel_bus(ext_sel_bus),
    .ext_capture(ext_capture), .ext_shift(ext_shift), .ext_update(ext_update),
    .run_idle(run_idle));

  // External scan register models driven only by the port strobes
  assign ext_tdo_ctrl = ctrl_reg[0];
  assign ext_tdo_bus  = bus_reg[0];
  always @(posedge tck) begin
    if (ext_capture) cap_cnt <= cap_cnt + 1;
    if (ext_update)  upd_cnt <= upd_cnt + 1;
    if (ext_capture && ext_sel_ctrl) ctrl_reg <= CTRL_CAP;
    if (ext_shift && ext_sel_ctrl)   ctrl_reg <= {tdi, ctrl_reg[7:1]};
    if (ext_capture && ext_sel_bus)  bus_reg <= BUS_CAP;
    if (ext_shift && ext_sel_bus)    bus_reg <= {tdi, bus_reg[11:1]};
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] idcode_exp();
    return {VER, PART, MANUF, 1'b1};
  endfunction

  // 0 bypass, 1 idcode, 2 ctrl, 3 bus
  function automatic int path_of(logic [IR_W-1:0] code);
    if (code == IR_W'(5'h01)) return 1;
    if (code == IR_W'(5'h10)) return 2;
    if (code == IR_W'(5'h11)) return 3;
    return 0;
  endfunction

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1; tms = m; tdi = d;
    #3; o = tdo; oe = tdo_oe;
    @(posedge tck); #1;
    if (oe) check(tdo === o, "R9 tdo moved on rising edge", 64'(tdo), 64'(o));
  endtask

  task automatic go(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o, oe;
    dout = '0;
    go(1'b1);
    if (is_ir) go(1'b1);
    go(1'b0);
    go(1'b0);
    for (int i = 0; i < n; i++) begin
      step(i == n-1, din[i], o, oe);
      dout[i] = o;
      check(oe === 1'b1, "R9 oe in shift", 64'(oe), 64'd1);
    end
    go(1'b1);
    go(1'b0);
    #4;
    check(run_idle === 1'b1 && tdo_oe === 1'b0, "R10 idle after scan", {62'd0, run_idle, tdo_oe}, 64'h2);
  endtask

  task automatic load_ir(input logic [IR_W-1:0] code);
    logic [63:0] cap;
    scan(1'b1, IR_W, 64'(code), cap);
    check(cap[IR_W-1:0] === IR_W'(1), "R3 IR capture pattern", cap, 64'd1);
  endtask

  task automatic data_check(input logic [IR_W-1:0] code, input int nb);
    logic [63:0] din, dout, exp;
    int p, n, ce, ue;
    p = path_of(code);
    n = (p == 1) ? 32 : (p == 2) ? 8 : (p == 3) ? 12 : nb;
    din = {$urandom, $urandom};
    ce = cap_cnt; ue = upd_cnt;
    scan(1'b0, n, din, dout);
    case (p)
      1: exp = 64'(idcode_exp());
      2: exp = 64'(CTRL_CAP);
      3: exp = 64'(BUS_CAP);
      default: exp = {din[62:0], 1'b0};
    endcase
    if (n < 64) begin
      exp  = exp  & ((64'd1 << n) - 1);
      dout = dout & ((64'd1 << n) - 1);
    end
    if (p == 1)      check(dout === exp, "R5 idcode read", dout, exp);
    else if (p >= 2) check(dout === exp, "R6 external route", dout, exp);
    else if (code == '0 || code == '1) check(dout === exp, "R4 bypass code", dout, exp);
    else             check(dout === exp, "R7 unimplemented to bypass", dout, exp);
    check((cap_cnt - ce) == ((p >= 2) ? 1 : 0) && (upd_cnt - ue) == ((p >= 2) ? 1 : 0),
          "R8 strobe count", 64'((cap_cnt - ce) * 16 + (upd_cnt - ue)), (p >= 2) ? 64'h11 : 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [IR_W-1:0] codes [10];
    void'($urandom(32'h5EED));
    codes = '{6'h00, 6'h3f, 6'h01, 6'h10, 6'h11, 6'h12, 6'h17, 6'h1f, 6'h30, 6'h31};
    #23;
    check(tdo_oe === 1'b0 && ext_sel_ctrl === 1'b0 && ext_sel_bus === 1'b0, "R1 reset outputs",
          {61'd0, tdo_oe, ext_sel_ctrl, ext_sel_bus}, 64'd0);
    check(run_idle === 1'b0, "R10 not idle in reset", 64'(run_idle), 64'd0);
    trst_n = 1'b1;
    go(1'b0);
    #4;
    check(run_idle === 1'b1, "R10 idle entered", 64'(run_idle), 64'd1);
    scan(1'b0, 32, 64'hFFFF_FFFF, d);
    check(d[31:0] === idcode_exp(), "R5 idcode selected after reset", d, 64'(idcode_exp()));
    scan(1'b0, 32, 64'h0, d);
    check(d[31:0] === idcode_exp(), "R5 idcode read-only", d, 64'(idcode_exp()));

    foreach (codes[i]) begin
      load_ir(codes[i]);
      check(ext_sel_ctrl === (path_of(codes[i]) == 2) && ext_sel_bus === (path_of(codes[i]) == 3),
            "R6 select lines", {62'd0, ext_sel_ctrl, ext_sel_bus}, 64'(path_of(codes[i])));
      data_check(codes[i], 17);
    end

    // asynchronous reset in the middle of a shift
    load_ir(6'h10);
    go(1'b1); go(1'b0); go(1'b0); go(1'b0);
    @(negedge tck); #2;
    trst_n = 1'b0; #1;
    check(tdo_oe === 1'b0 && ext_sel_ctrl === 1'b0, "R1 async reset mid-shift",
          {62'd0, tdo_oe, ext_sel_ctrl}, 64'd0);
    #10; trst_n = 1'b1;
    go(1'b0);
    data_check(6'h01, 32);

    // random walks then five high tms edges
    for (int w = 0; w < 12; w++) begin
      logic o, oe;
      int len = $urandom_range(3, 40);
      for (int k = 0; k < len; k++) step(1'($urandom), 1'($urandom), o, oe);
      for (int k = 0; k < 5; k++) go(1'b1);
      go(1'b0);
      #4;
      check(run_idle === 1'b1 && ext_sel_ctrl === 1'b0 && ext_sel_bus === 1'b0,
            "R2 five tms high reset", {61'd0, run_idle, ext_sel_ctrl, ext_sel_bus}, 64'h4);
      scan(1'b0, 32, {$urandom, $urandom}, d);
      check(d[31:0] === idcode_exp(), "R2 IR back to idcode", d, 64'(idcode_exp()));
    end

    // random instruction codes mixed with directed ones
    for (int r = 0; r < 40; r++) begin
      logic [IR_W-1:0] c;
      c = ($urandom_range(0, 2) == 0) ? codes[$urandom_range(0, 9)] : IR_W'($urandom);
      load_ir(c);
      data_check(c, $urandom_range(2, 48));
    end

    finish_run();
  end

endmodule